// File: doc/BRIEF.md
# Vertical-Blank NMI Flag Generator

This block watches the horizontal and vertical position of a video timing source and derives two separate vertical-blank signals. The first is a status flag that software reads through a status register. Reading the register returns the flag in bit 7 and clears it. The second is an active-low interrupt request line, `nmi_n`, that goes to the CPU core.

Both signals are raised on the first line of vertical blank. The flag rises at horizontal count 2. The line falls at horizontal count 6, four master clocks later. The two signals are cleared by different events.

- The flag is cleared by a status read or by a control write with bit 7 at zero. It survives the start of a new frame.
- The line is released when the CPU acknowledges it on the last bus cycle of an instruction, or at the start of a new frame.

When the CPU acknowledges, the block also reports whether the interrupt should be taken. That depends on the enable bit held from the last control write. The horizontal count is in master-clock units, with four per dot and 1364 per line. The vertical count runs 0 to 261.

Top module: `vblank_nmi_gen`

## Requirements
- R1: The vertical-blank start line is 225 when `overscan` is 0 and 240 when `overscan` is 1. No flag or line event occurs on the other of the two lines.
- R2: When `vpos` equals the start line and `hpos` equals 2 at a clock edge, the status flag is set from that edge on.
- R3: When `vpos` equals the start line and `hpos` equals 6 at a clock edge, `nmi_n` is 0 after that edge, whatever the enable bit is. At horizontal counts 2 to 5 of that line it is still 1.
- R4: A `stat_rd` pulse loads `stat_flag` with the flag value at that edge. `stat_flag` holds that value until the next read. The read then clears the flag.
- R5: A `stat_rd` on the same edge at which the flag is set returns 1 and leaves the flag set.
- R6: A `ctl_wr` with `ctl_wdata` bit 7 equal to 0 clears the flag, unless the flag is being set on that same edge. A write with bit 7 equal to 1 leaves the flag unchanged.
- R7: At `vpos`=0 and `hpos`=0, `nmi_n` returns to 1 and the status flag is unchanged.
- R8: An `ack_last` pulse while `nmi_n` is 0 returns `nmi_n` to 1 after the edge. On an edge where the line-assert event also occurs, the assert wins.
- R9: `take_nmi` is 1 for exactly the cycle after an edge where `ack_last`=1, `nmi_n`=0 and the enable bit (bit 7 of the last `ctl_wdata` written) is 1. Otherwise it is 0.
- R10: While `rst` is high: `stat_flag`=0, `nmi_n`=1, `take_nmi`=0, and both the flag and the enable bit are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| hpos | input | 11 | Horizontal count, master clocks, 0..1363 |
| vpos | input | 9 | Vertical count, lines, 0..261 |
| overscan | input | 1 | Selects line 240 instead of 225 as the vertical-blank start |
| stat_rd | input | 1 | Single-cycle status register read strobe |
| ctl_wr | input | 1 | Single-cycle control register write strobe |
| ctl_wdata | input | 8 | Control write data; bit 7 is the NMI enable |
| ack_last | input | 1 | Single-cycle pulse on the last bus cycle of an instruction |
| stat_flag | output | 1 | Registered bit 7 of the last status read |
| nmi_n | output | 1 | Active-low NMI request line to the CPU |
| take_nmi | output | 1 | One-cycle pulse: the CPU should service NMI |

## Verification
The assertions assume that `stat_rd`, `ctl_wr` and `ack_last` are single-cycle strobes. They also assume that `hpos` and `vpos` stay inside their stated ranges and change only with the clock.

The bench drives every input on the falling edge. It places each position directly, instead of running a full frame. It only ever chooses values inside those ranges, so that each event lands on one known edge.

Every result is sampled on the falling edge that follows the edge of interest.

// File: rtl/nmi_gen_pkg.sv
package nmi_gen_pkg;
  // events decoded from the timing position, one edge wide
  typedef struct packed {
    logic flag_set;    // readable flag rises
    logic line_set;    // /NMI falls
    logic frame_start; // first dot of a frame
  } nmi_evt_t;
endpackage

// File: rtl/nmi_evt_decode.sv
module nmi_evt_decode
  import nmi_gen_pkg::*;
#(
  parameter int HCNT_W      = 11,
  parameter int VCNT_W      = 9,
  parameter int VBL_LINE    = 225,
  parameter int VBL_LINE_OS = 240,
  parameter int FLAG_HPOS   = 2,
  parameter int LINE_HPOS   = 6
) (
  input  logic [HCNT_W-1:0] hpos,
  input  logic [VCNT_W-1:0] vpos,
  input  logic              overscan,
  output nmi_evt_t          evt
);
  localparam logic [VCNT_W-1:0] LINE_N  = VCNT_W'(VBL_LINE);
  localparam logic [VCNT_W-1:0] LINE_OS = VCNT_W'(VBL_LINE_OS);
  localparam logic [HCNT_W-1:0] H_FLAG  = HCNT_W'(FLAG_HPOS);
  localparam logic [HCNT_W-1:0] H_LINE  = HCNT_W'(LINE_HPOS);

  logic [VCNT_W-1:0] start_line;
  logic              on_start;

  always_comb begin
    start_line      = overscan ? LINE_OS : LINE_N;
    on_start        = (vpos == start_line);
    evt.flag_set    = on_start && (hpos == H_FLAG);
    evt.line_set    = on_start && (hpos == H_LINE);
    evt.frame_start = (vpos == '0) && (hpos == '0);
  end
endmodule

// File: rtl/nmi_status_flag.sv
module nmi_status_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic frame_ev,
  input  logic rd,
  input  logic wr_clear,
  output logic flag_q,
  output logic rdata_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= 1'b0;
      rdata_q <= 1'b0;
    end else begin
      if (set_ev)
        flag_q <= 1'b1;
      else if (rd || wr_clear)
        flag_q <= 1'b0;
      if (rd)
        rdata_q <= flag_q | set_ev;
    end
  end

  // R2
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> flag_q);
  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !set_ev) |=> !flag_q);
  // R5
  read_race_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && set_ev) |=> (flag_q && rdata_q));
  // R7
  frame_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_ev && !set_ev && !rd && !wr_clear) |=> (flag_q == $past(flag_q)));
endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl #(
  parameter int CTL_W  = 8,
  parameter int EN_BIT = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_ev,
  input  logic             frame_ev,
  input  logic             ack,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             nmi_n_q,
  output logic             take_q
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_n_q <= 1'b1;
      take_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      if (ctl_wr)
        en_q <= ctl_wdata[EN_BIT];
      if (line_ev)
        nmi_n_q <= 1'b0;
      else if (frame_ev || (ack && !nmi_n_q))
        nmi_n_q <= 1'b1;
      take_q <= ack && !nmi_n_q && en_q;
    end
  end

  // R3
  line_fall_chk: assert property (@(posedge clk) disable iff (rst)
    line_ev |=> !nmi_n_q);
  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && !nmi_n_q && !line_ev) |=> nmi_n_q);
  // R9
  take_cond_chk: assert property (@(posedge clk) disable iff (rst)
    take_q |-> ($past(ack) && !$past(nmi_n_q) && $past(en_q)));
  // R9
  take_single_chk: assert property (@(posedge clk) disable iff (rst)
    take_q |=> !take_q);
endmodule

// File: rtl/vblank_nmi_gen.sv
module vblank_nmi_gen
  import nmi_gen_pkg::*;
#(
  parameter int HCNT_W      = 11,
  parameter int VCNT_W      = 9,
  parameter int CTL_W       = 8,
  parameter int VBL_LINE    = 225,
  parameter int VBL_LINE_OS = 240,
  parameter int FLAG_HPOS   = 2,
  parameter int LINE_HPOS   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HCNT_W-1:0] hpos,
  input  logic [VCNT_W-1:0] vpos,
  input  logic              overscan,
  input  logic              stat_rd,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              ack_last,
  output logic              stat_flag,
  output logic              nmi_n,
  output logic              take_nmi
);
  localparam int EN_BIT = CTL_W - 1;

  nmi_evt_t evt;
  logic     wr_clear;
  logic     flag_q;

  assign wr_clear = ctl_wr && !ctl_wdata[EN_BIT];

  nmi_evt_decode #(
    .HCNT_W(HCNT_W), .VCNT_W(VCNT_W),
    .VBL_LINE(VBL_LINE), .VBL_LINE_OS(VBL_LINE_OS),
    .FLAG_HPOS(FLAG_HPOS), .LINE_HPOS(LINE_HPOS)
  ) u_dec (
    .hpos(hpos), .vpos(vpos), .overscan(overscan), .evt(evt)
  );

  nmi_status_flag u_flag (
    .clk(clk), .rst(rst),
    .set_ev(evt.flag_set), .frame_ev(evt.frame_start),
    .rd(stat_rd), .wr_clear(wr_clear),
    .flag_q(flag_q), .rdata_q(stat_flag)
  );

  nmi_line_ctrl #(.CTL_W(CTL_W), .EN_BIT(EN_BIT)) u_line (
    .clk(clk), .rst(rst),
    .line_ev(evt.line_set), .frame_ev(evt.frame_start),
    .ack(ack_last), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .nmi_n_q(nmi_n), .take_q(take_nmi)
  );

  // R10
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (nmi_n && !take_nmi && !stat_flag && !flag_q));
  // R6
  wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_clear && !evt.flag_set) |=> !flag_q);
endmodule

// File: tb/vblank_nmi_gen_test.sv
module vblank_nmi_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] hpos = '0;
  logic [8:0]  vpos = '0;
  logic        overscan = 1'b0;
  logic        stat_rd = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        ack_last = 1'b0;
  logic        stat_flag, nmi_n, take_nmi;
  int          n_cmp = 0;
  int          n_bad = 0;
  int          cyc = 0;

  always #4 clk = ~clk;

  vblank_nmi_gen uut (
    .clk(clk), .rst(rst), .hpos(hpos), .vpos(vpos), .overscan(overscan),
    .stat_rd(stat_rd), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ack_last(ack_last), .stat_flag(stat_flag), .nmi_n(nmi_n),
    .take_nmi(take_nmi)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_cmp = n_cmp + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%b exp=%b", tag, act, exp);
    end
  endtask

  // drive on falling edge, one rising edge, return on next falling edge
  task automatic tick(input int v, input int h, input bit rd = 0,
                      input bit wr = 0, input logic [7:0] d = 8'h00,
                      input bit ack = 0);
    vpos = 9'(v); hpos = 11'(h);
    stat_rd = rd; ctl_wr = wr; ctl_wdata = d; ack_last = ack;
    @(posedge clk);
    @(negedge clk);
    stat_rd = 0; ctl_wr = 0; ack_last = 0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(stat_flag, 1'b0, "R10 stat_flag");
    chk(nmi_n, 1'b1, "R10 nmi_n");
    chk(take_nmi, 1'b0, "R10 take_nmi");
    rst = 1'b0;
    tick(100, 0, 1);
    chk(stat_flag, 1'b0, "R10 flag clear after reset");
  endtask

  task automatic t_timing;
    overscan = 0;
    tick(225, 1, 1);  chk(stat_flag, 1'b0, "R2 flag before h2");
    tick(225, 2);
    tick(225, 3, 1);  chk(stat_flag, 1'b1, "R2 flag at h2");
    chk(nmi_n, 1'b1, "R3 line high at h3");
    tick(225, 4, 1);  chk(stat_flag, 1'b0, "R4 read cleared flag");
    tick(225, 5);     chk(nmi_n, 1'b1, "R3 line high at h5");
    tick(225, 6);     chk(nmi_n, 1'b0, "R3 line low at h6 enable off");
  endtask

  task automatic t_race;
    tick(0, 0);       chk(nmi_n, 1'b1, "R7 release at frame start");
    tick(225, 2, 1);  chk(stat_flag, 1'b1, "R5 read on set edge");
    tick(225, 3, 1);  chk(stat_flag, 1'b1, "R5 flag not cleared");
    tick(225, 4, 1);  chk(stat_flag, 1'b0, "R4 second read cleared");
  endtask

  task automatic t_overscan;
    overscan = 1;
    tick(225, 2);
    tick(225, 6);     chk(nmi_n, 1'b1, "R1 no line event at 225 overscan");
    tick(225, 7, 1);  chk(stat_flag, 1'b0, "R1 no flag at 225 overscan");
    tick(240, 2);
    tick(240, 3, 1);  chk(stat_flag, 1'b1, "R1 flag at 240 overscan");
    tick(240, 6);     chk(nmi_n, 1'b0, "R1 line low at 240 overscan");
    overscan = 0;
    tick(240, 2);
    tick(240, 3, 1);  chk(stat_flag, 1'b0, "R1 no flag at 240 normal");
  endtask

  task automatic t_ctl;
    tick(225, 2);
    tick(225, 3, 0, 1, 8'h80);
    tick(225, 4, 1);  chk(stat_flag, 1'b1, "R6 bit7 set keeps flag");
    tick(225, 2);
    tick(225, 3, 0, 1, 8'h00);
    tick(225, 4, 1);  chk(stat_flag, 1'b0, "R6 bit7 clear clears flag");
    tick(225, 2, 0, 1, 8'h00);
    tick(225, 3, 1);  chk(stat_flag, 1'b1, "R6 set wins over write clear");
  endtask

  task automatic t_frame;
    tick(225, 2);
    tick(225, 6);     chk(nmi_n, 1'b0, "R3 line low before frame");
    tick(0, 0);       chk(nmi_n, 1'b1, "R7 frame start releases line");
    tick(0, 1, 1);    chk(stat_flag, 1'b1, "R7 flag survives frame start");
  endtask

  task automatic t_ack;
    tick(225, 6);     chk(nmi_n, 1'b0, "R8 setup low");
    tick(225, 10, 0, 0, 8'h00, 1);
    chk(take_nmi, 1'b0, "R9 no take when disabled");
    chk(nmi_n, 1'b1, "R8 ack releases line");
    tick(0, 5, 0, 1, 8'h80);
    tick(225, 6);
    tick(225, 10, 0, 0, 8'h00, 1);
    chk(take_nmi, 1'b1, "R9 take when enabled");
    chk(nmi_n, 1'b1, "R8 ack releases enabled line");
    tick(225, 11);    chk(take_nmi, 1'b0, "R9 take single cycle");
    tick(225, 12, 0, 0, 8'h00, 1);
    chk(take_nmi, 1'b0, "R9 no take with line high");
    tick(225, 6, 0, 0, 8'h00, 1);
    chk(nmi_n, 1'b0, "R8 assert wins over ack");
    chk(take_nmi, 1'b0, "R9 no take when line was high");
  endtask

  initial begin
    @(negedge clk);
    t_reset;
    t_timing;
    t_race;
    t_overscan;
    t_ctl;
    t_frame;
    t_ack;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule